// File: doc/BRIEF.md
# Shared Timer Prescaler Clock Select

This block makes the count-enable pulses for two timer channels. Both channels draw on one free-running 10-bit divider. Each channel has its own 3-bit select that picks its source:

- stopped;
- every system clock cycle;
- one of four divider taps, at divide-by 8, 64, 256 or 1024;
- a falling-edge strobe from external pin logic;
- a rising-edge strobe from external pin logic.

The output for each channel is a one-cycle enable, registered on the system clock. The timer counter it belongs to advances on each cycle that the enable is high.

Changing a select does not clear or pause the divider. The first prescaled enable after a select change therefore comes after a delay set by the divider's current phase. A synchronous clear input restarts the divider. Software can use it to line timer counting up with a known point in program flow. The edge strobes come from a separate pin synchronizer and pass straight through this block, with one register stage.

Top module: `tmr_presc_sel`

## Requirements
- R1: While `rst_n` is low, every `cnt_en_o` bit is 0 at each clock edge and the divider is held at 0.
- R2: Select code 0 gives no enable pulses on that channel.
- R3: Select code 1 gives an enable on every clock cycle, one edge after the code is applied.
- R4: Select codes 2, 3, 4 and 5 pick divide-by 8, 64, 256 and 1024. The enable is high one edge after a cycle in which the low 3, 6, 8 or 10 divider bits are all zero.
- R5: After reset, the divider counts up by one on every clock edge and wraps at 1024. Select values have no effect on it.
- R6: After a channel switches from code 0 to a prescaled code with divisor N, its first enable appears between 1 and N+1 cycles later.
- R7: When `presc_clr` is high at an edge, the divider becomes 0. A channel on a tap then pulses on the next edge, and after that every N cycles.
- R8: Select code 6 copies that channel's falling-edge strobe to its enable, delayed by one edge.
- R9: Select code 7 copies that channel's rising-edge strobe to its enable, delayed by one edge.
- R10: Each channel's enable depends only on its own select field (bits [3c+2:3c]) and its own strobes, together with the shared divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_clr | input | 1 | Synchronous divider restart |
| sel_i | input | 6 | Per-channel 3-bit source select; channel c uses bits [3c+2:3c] |
| ext_rise_i | input | 2 | Per-channel rising-edge strobe from pin logic |
| ext_fall_i | input | 2 | Per-channel falling-edge strobe from pin logic |
| cnt_en_o | output | 2 | Per-channel one-cycle count enable |

## Verification
The divider is not visible at the ports. If it holds a wrong value, the only sign is a tap enable at the wrong phase. A fault in the low bits shows within 8 cycles on a divide-by-8 channel. A fault in the top bits may stay hidden for up to 1024 cycles, until a divide-by-1024 channel misses its wrap. A wrong decode, or a crossed channel field, shows on the very next edge under the full-rate and strobe codes. For that reason, every cycle is compared against a bench model of the divider, and the cycles after a clear get their own checks.

// File: rtl/tps_pkg.sv
// Package for the timer prescaler select block.
// Holds the source-select codes and the bit width of each divider tap.
package tps_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF  = 3'd0,
        SRC_SYS  = 3'd1,
        SRC_D8   = 3'd2,
        SRC_D64  = 3'd3,
        SRC_D256 = 3'd4,
        SRC_D1K  = 3'd5,
        SRC_FALL = 3'd6,
        SRC_RISE = 3'd7
    } src_sel_e;

    // Number of low divider bits that must be zero for tap t to fire.
    function automatic int tap_bits(input int t);
        case (t)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tps_divider.sv
// Free-running shared divider.
// The count advances on every clock. Only reset or clear sets it back to 0.
// tick_o[t] is high while the low tap_bits(t) bits of the count are zero.
// Assumes DIV_W >= tap_bits of the widest tap.
module tps_divider #(
    parameter int DIV_W    = 10,
    parameter int NUM_TAPS = tps_pkg::NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    output logic [NUM_TAPS-1:0] tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Count every cycle; restart on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // One tap decode per divisor.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int B = tps_pkg::tap_bits(t);
        assign tick_o[t] = (cnt_q[B-1:0] == '0);
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R7

    AST_CNT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == DIV_W'($past(cnt_q) + 1))); // R5

    for (genvar t = 1; t < NUM_TAPS; t++) begin : g_nest_chk
        AST_TAP_NEST: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[t] |-> tick_o[t-1]); // R4
    end

endmodule

// File: rtl/tps_chan_sel.sv
// Source selection for one channel.
// Decodes the 3-bit select and registers the chosen source as a one-cycle enable.
// Assumes the edge strobes are already synchronous single-cycle pulses.
module tps_chan_sel #(
    parameter int NUM_TAPS = tps_pkg::NUM_TAPS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [tps_pkg::SEL_W-1:0]  sel_i,
    input  logic [NUM_TAPS-1:0]        tick_i,
    input  logic                       rise_i,
    input  logic                       fall_i,
    output logic                       en_o
);
    import tps_pkg::*;

    src_sel_e src;
    logic     en_d;

    assign src = src_sel_e'(sel_i);

    // Pick the source for this cycle.
    always_comb begin
        unique case (src)
            SRC_OFF:  en_d = 1'b0;
            SRC_SYS:  en_d = 1'b1;
            SRC_D8:   en_d = tick_i[0];
            SRC_D64:  en_d = tick_i[1];
            SRC_D256: en_d = tick_i[2];
            SRC_D1K:  en_d = tick_i[NUM_TAPS-1];
            SRC_FALL: en_d = fall_i;
            SRC_RISE: en_d = rise_i;
            default:  en_d = 1'b0;
        endcase
    end

    // Register the enable so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) en_o <= 1'b0;
        else        en_o <= en_d;
    end

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd0) |=> !en_o); // R2

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd1) |=> en_o); // R3

    AST_TAP8_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd2) |=> (en_o == $past(tick_i[0]))); // R4

    AST_FALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd6) |=> (en_o == $past(fall_i))); // R8

    AST_RISE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd7) |=> (en_o == $past(rise_i))); // R9

endmodule

// File: rtl/tmr_presc_sel.sv
// Top level: one shared divider and one select stage per channel.
// Channel c reads select bits [3c+2:3c] and its own edge strobes (R10).
module tmr_presc_sel #(
    parameter int NUM_CH = 2,
    parameter int DIV_W  = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             presc_clr,
    input  logic [NUM_CH*tps_pkg::SEL_W-1:0] sel_i,
    input  logic [NUM_CH-1:0]                ext_rise_i,
    input  logic [NUM_CH-1:0]                ext_fall_i,
    output logic [NUM_CH-1:0]                cnt_en_o
);
    localparam int SW = tps_pkg::SEL_W;
    localparam int NT = tps_pkg::NUM_TAPS;

    logic [NT-1:0] tick;

    tps_divider #(.DIV_W(DIV_W), .NUM_TAPS(NT)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (presc_clr),
        .tick_o (tick)
    );

    // One select stage per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tps_chan_sel #(.NUM_TAPS(NT)) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel_i[c*SW +: SW]),
            .tick_i (tick),
            .rise_i (ext_rise_i[c]),
            .fall_i (ext_fall_i[c]),
            .en_o   (cnt_en_o[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (cnt_en_o == '0)); // R1

endmodule

// File: tb/tmr_presc_sel_tb.sv
module tmr_presc_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_clr = 1'b0;
    logic [5:0] sel_i = '0;
    logic [1:0] ext_rise_i = '0;
    logic [1:0] ext_fall_i = '0;
    logic [1:0] cnt_en_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int mcnt   = 0;   // bench model of the divider

    always #5 clk = ~clk;

    tmr_presc_sel dut_i (
        .clk(clk), .rst_n(rst_n), .presc_clr(presc_clr), .sel_i(sel_i),
        .ext_rise_i(ext_rise_i), .ext_fall_i(ext_fall_i), .cnt_en_o(cnt_en_o)
    );

    function automatic int divisor(input logic [2:0] s);
        case (s)
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic exp_en(input logic [2:0] s, input int cnt,
                                    input logic r, input logic f);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd6: return f;
            3'd7: return r;
            default: return ((cnt % divisor(s)) == 0);
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd6: return "R8";
            3'd7: return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Called at a negedge: drive inputs, cross one posedge, compare at the next negedge.
    task automatic step(input logic clr, input logic [5:0] s, input logic [1:0] r,
                        input logic [1:0] f, input string extra);
        logic [1:0] e;
        presc_clr = clr; sel_i = s; ext_rise_i = r; ext_fall_i = f;
        for (int c = 0; c < 2; c++) e[c] = exp_en(s[c*3 +: 3], mcnt, r[c], f[c]);
        @(posedge clk);
        mcnt = clr ? 0 : (mcnt + 1) % 1024;
        @(negedge clk);
        for (int c = 0; c < 2; c++)
            check(cnt_en_o[c], e[c], $sformatf("%s/R10 ch%0d %s", tag_of(s[c*3 +: 3]), c, extra));
    endtask

    initial begin
        int seed;
        int lat;
        logic [5:0] s;
        seed = 32'h5eed;
        void'($urandom(seed));

        // R1: the enables stay low during reset, even with full-rate selected.
        sel_i = 6'b001_001;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cnt_en_o[0], 1'b0, "R1 ch0 in reset");
        check(cnt_en_o[1], 1'b0, "R1 ch1 in reset");
        rst_n = 1'b1;
        mcnt = 0;

        // R4 after reset: the divider starts at 0, so divide-by-8 fires at once.
        for (int i = 0; i < 40; i++) step(1'b0, 6'b011_010, 2'b00, 2'b00, "R1 post-reset");

        // R5: ch0 stays on divide-by-8 while ch1 hops between codes at random.
        for (int i = 0; i < 400; i++)
            step(1'b0, {3'($urandom_range(0, 7)), 3'd2}, 2'($urandom), 2'($urandom), "R5");

        // R6: go from code 0 to divide-by-1024 at a random phase and time the first enable.
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < int'($urandom_range(1, 600)); i++)
                step(1'b0, 6'b000_000, 2'b00, 2'b00, "R6 idle");
            lat = 0;
            do begin
                step(1'b0, 6'b000_101, 2'b00, 2'b00, "R6");
                lat++;
            end while (cnt_en_o[0] !== 1'b1 && lat < 1100);
            checks++;
            if (lat < 1 || lat > 1025) begin
                errors++;
                $display("FAIL R6: actual latency=%0d expected 1..1025", lat);
            end
        end

        // R7: a clear restarts the divider; the next edge brings a tap pulse.
        for (int i = 0; i < 13; i++) step(1'b0, 6'b100_010, 2'b00, 2'b00, "R7 pre");
        step(1'b1, 6'b100_010, 2'b00, 2'b00, "R7 clr");
        step(1'b0, 6'b100_010, 2'b00, 2'b00, "R7 first");
        check(cnt_en_o[1], 1'b1, "R7 ch1 d256 right after clear");
        for (int i = 0; i < 300; i++) step(1'b0, 6'b100_010, 2'b00, 2'b00, "R7");

        // R8 / R9: strobe pass-through with opposite polarities on the two channels.
        for (int i = 0; i < 64; i++) step(1'b0, 6'b111_110, 2'($urandom), 2'($urandom), "R8 R9");

        // Random mix: selects, strobes and occasional clears.
        s = '0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) s = 6'($urandom);
            step(($urandom_range(0, 199) == 0), s, 2'($urandom), 2'($urandom), "rand");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule